// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Model

This block is a synthesizable behavioural model of a synchronous, flow-through static RAM. The data bus needs no idle cycle between a read and a write. The array is small: by default 256 words of 36 bits, split into four byte lanes of 9 bits. On every rising edge where the active-low clock enable is asserted, the block samples its command pins. A load starts an access. The access is either a single word or a four-word burst. During a burst the block steps the two lowest address bits itself, in linear or interleaved order, and a static mode pin selects which.

Read data flows through. A read loaded at edge N appears on the data-out port during the cycle that follows edge N, and only while output enable is low. Write data trails its command by one enabled edge. The byte-lane enables travel with the command, so each lane mask leads its data word by one cycle. A held-off clock enable makes that edge count for nothing: no register in the block changes. The output bus is modelled as a data-out vector plus a drive-enable flag.

The controller has three states. `ST_IDLE` means no access is in progress. `ST_READ` and `ST_WRITE` mean a selected access is active in that direction. The transitions are:
- LOAD_RD: advance/load low, selected, read/write high; goes to `ST_READ`.
- LOAD_WR: advance/load low, selected, read/write low; goes to `ST_WRITE`.
- DESELECT: advance/load low, not selected; goes to `ST_IDLE`.
- ADVANCE: advance/load high; the state is kept and the burst count steps, except in `ST_IDLE`, where nothing changes.
- HOLD: clock enable high; nothing changes.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the block is in `ST_IDLE` and `rdata_oe` is 0.
- R2: A load selects the device only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination on a load is a DESELECT. It ends any burst and makes no access, and an ADVANCE that follows it also makes no access.
- R3: A read loaded at enabled edge N drives the stored word of the loaded address on `rdata`, with `rdata_oe`=1, during the cycle after edge N, provided `oe_n`=0.
- R4: `rdata_oe` is 1 only when `oe_n` is 0 and a selected read is active. Whenever `rdata_oe` is 0, `rdata` is all zeros.
- R5: A load with `rw`=0 starts a write. Its data is taken from `wdata` at the next enabled edge. A lane is written only if its bit of `bw_n` was 0 at the command edge; lane i covers bits [9i+8:9i].
- R6: An ADVANCE keeps the upper address bits and steps a 2-bit burst count. The fifth word of a burst returns to the start address.
- R7: With `burst_mode`=0 (linear), word k of a burst uses low address bits (start + k) mod 4.
- R8: With `burst_mode`=1 (interleaved), word k of a burst uses low address bits start XOR k.
- R9: During an ADVANCE, `rw` is ignored. The direction stays as it was set by the load.
- R10: When `cke_n` is 1 at an edge, no state, address, count or lane mask changes, and `wdata` is not taken.
- R11: A read loaded on the edge right after a write command to the same address returns the newly written data.
- R12: A new load ends a burst in progress and starts at the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rw | input | 1 | 1 = read, 0 = write; sampled on loads only |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Byte-lane write enables, active low |
| burst_mode | input | 1 | 0 = linear, 1 = interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data, one enabled edge after its command |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Data bus drive enable |

## Verification
Some rules are checked by assertions on every enabled cycle:
- a HOLD edge leaves state, base and count unchanged;
- an ADVANCE keeps the direction and base and adds one to the count;
- a DESELECT always lands in `ST_IDLE`;
- every load clears the count.

Other behaviour only the bench scenarios can show:
- the word order in both burst modes and the wrap on the fifth word;
- partial byte-lane merges;
- the one-edge lag of write data, including across a HOLD edge;
- read-after-write without a gap;
- the chip-enable combinations that deselect the device.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_t;

    localparam int unsigned BURST_BITS = 2;

    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  interleave
    );
        logic [BURST_BITS-1:0] res;
        if (interleave) res = start ^ step;
        else            res = start + step;
        return res;
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke_n,
    input  logic                  sel,
    input  logic                  adv_ld,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [LANES-1:0]      bw_n,
    output acc_state_t            state_q,
    output logic [ADDR_W-1:0]     base_q,
    output logic [BURST_BITS-1:0] cnt_q,
    output logic [LANES-1:0]      bw_q
);

    acc_state_t            state_d;
    logic [ADDR_W-1:0]     base_d;
    logic [BURST_BITS-1:0] cnt_d;
    logic                  load;

    assign load = !adv_ld;

    // next state: LOAD_RD, LOAD_WR, DESELECT, ADVANCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = !sel ? ST_IDLE : (rw ? ST_READ : ST_WRITE);
            end
            ST_READ, ST_WRITE: begin
                if (load) state_d = !sel ? ST_IDLE : (rw ? ST_READ : ST_WRITE);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // burst address registers
    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load) begin
            base_d = addr;
            cnt_d  = '0;
        end else if (state_q != ST_IDLE) begin
            cnt_d  = cnt_q + 1'b1;
        end
    end

    // state register; HOLD when cke_n is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            bw_q    <= '1;
        end else if (!cke_n) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            bw_q    <= bw_n;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(state_q) && $stable(base_q) && $stable(cnt_q) && $stable(bw_q)));

    assert_dir_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && state_q != ST_IDLE) |=> (state_q == $past(state_q)));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && state_q != ST_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)));

    assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> (state_q == ST_IDLE));

    assert_load_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld) |=> (cnt_q == '0 && base_q == $past(addr)));

endmodule

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]     base,
    input  logic [BURST_BITS-1:0] cnt,
    input  logic                  interleave,
    output logic [ADDR_W-1:0]     cur_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_BITS;

    generate
        if (HI_W > 0) begin : g_hi
            assign cur_addr = {base[ADDR_W-1:BURST_BITS],
                               burst_low(base[BURST_BITS-1:0], cnt, interleave)};
        end else begin : g_lo
            assign cur_addr = burst_low(base[BURST_BITS-1:0], cnt, interleave);
        end
    endgenerate

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [LANES-1:0]          lane_en,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    adv_ld,
    input  logic                    rw,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int unsigned DATA_W = LANES * LANE_W;

    acc_state_t            state_q;
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [LANES-1:0]      bw_q;
    logic [ADDR_W-1:0]     cur_addr;
    logic [DATA_W-1:0]     arr_rdata;
    logic                  sel;
    logic                  arr_we;

    assign sel = !sel_a_n && !sel_b_n && sel_c;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke_n   (cke_n),
        .sel     (sel),
        .adv_ld  (adv_ld),
        .rw      (rw),
        .addr    (addr),
        .bw_n    (bw_n),
        .state_q (state_q),
        .base_q  (base_q),
        .cnt_q   (cnt_q),
        .bw_q    (bw_q)
    );

    zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base       (base_q),
        .cnt        (cnt_q),
        .interleave (burst_mode),
        .cur_addr   (cur_addr)
    );

    // write commits on the enabled edge after its command
    assign arr_we = !cke_n && (state_q == ST_WRITE);

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (arr_we),
        .lane_en (~bw_q),
        .waddr   (cur_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (arr_rdata)
    );

    // output process
    always_comb begin
        rdata_oe = 1'b0;
        rdata    = '0;
        unique case (state_q)
            ST_READ: begin
                rdata_oe = !oe_n;
                rdata    = oe_n ? '0 : arr_rdata;
            end
            ST_IDLE, ST_WRITE: begin
                rdata_oe = 1'b0;
            end
            default: rdata_oe = 1'b0;
        endcase
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE));

endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int AW = 8;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n, cke_n, sel_a_n, sel_b_n, sel_c, adv_ld, rw;
    logic [AW-1:0] addr;
    logic [3:0]    bw_n;
    logic          burst_mode, oe_n;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_oe;

    int checks = 0;
    int errors = 0;

    zbt_sram dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .sel_c(sel_c), .adv_ld(adv_ld), .rw(rw), .addr(addr), .bw_n(bw_n),
        .burst_mode(burst_mode), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic          ck_n;
        logic          sel;
        logic          adv;
        logic          r;
        logic [AW-1:0] a;
        logic [3:0]    bw;
        logic [DW-1:0] wd;
        logic          oe;
        logic          e_oe;
        logic [DW-1:0] e_d;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'b0000, 36'h0, 1'b0, 1'b0, 36'h0},                   // R5 write cmd
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 4'b0000, 36'h0AAAA5555, 1'b0, 1'b0, 36'h0},           // R5 data 0x10
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'b1111, 36'h123456789, 1'b0, 1'b1, 36'h0AAAA5555},   // R3 R11
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 4'b1111, 36'h0, 1'b0, 1'b1, 36'h123456789},           // R3
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'b1010, 36'h0, 1'b0, 1'b0, 36'h0},                   // R5 lanes 0,2
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'b1111, 36'hFFFFFFFFF, 1'b0, 1'b1, 36'h0AFFE55FF},   // R5 R11 merge
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'b1111, 36'h0, 1'b1, 1'b0, 36'h0},                   // R4 oe_n high
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 4'b1111, 36'h0, 1'b0, 1'b0, 36'h0},                   // R2 deselect
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h10, 4'b1111, 36'h0, 1'b0, 1'b0, 36'h0},                   // R2 advance idle
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h11, 4'b1111, 36'h0, 1'b0, 1'b0, 36'h0}                    // R10 frozen load
    };

    task automatic cyc(input logic ck, input logic an, input logic bn, input logic c,
                       input logic adv, input logic r, input logic [AW-1:0] a,
                       input logic [3:0] bw, input logic [DW-1:0] wd, input logic oe);
        @(negedge clk);
        cke_n = ck; sel_a_n = an; sel_b_n = bn; sel_c = c; adv_ld = adv; rw = r;
        addr = a; bw_n = bw; wdata = wd; oe_n = oe;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic e_oe, input logic [DW-1:0] e_d);
        logic [DW-1:0] exp_d;
        exp_d = e_oe ? e_d : '0;
        checks++;
        if (rdata_oe !== e_oe || rdata !== exp_d) begin
            errors++;
            $display("FAIL %s oe=%0b exp %0b data=%h exp %h", tag, rdata_oe, e_oe, rdata, exp_d);
        end
    endtask

    task automatic ld_rd(input logic [AW-1:0] a);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 4'hF, '0, 1'b0);
    endtask

    task automatic adv_step(input logic r, input logic [DW-1:0] wd);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, r, 8'h00, 4'h0, wd, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cke_n = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
        adv_ld = 1'b1; rw = 1'b1; addr = '0; bw_n = '1; burst_mode = 1'b0;
        oe_n = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset idle", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].ck_n, !VECS[i].sel, 1'b0, 1'b1, VECS[i].adv, VECS[i].r,
                VECS[i].a, VECS[i].bw, VECS[i].wd, VECS[i].oe);
            check($sformatf("R2 R3 R4 R5 R10 R11 vector %0d", i), VECS[i].e_oe, VECS[i].e_d);
        end

        // linear burst write from 0x22: order 2,3,0,1; rw toggled high (R9)
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h22, 4'h0, '0, 1'b0);
        adv_step(1'b1, 36'h111111111);
        adv_step(1'b1, 36'h222222222);
        adv_step(1'b1, 36'h333333333);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 4'hF, 36'h444444444, 1'b0);
        check("R9 burst write not turned to read", 1'b0, '0);
        ld_rd(8'h22); check("R7 linear word0", 1'b1, 36'h111111111);
        ld_rd(8'h23); check("R7 linear word1", 1'b1, 36'h222222222);
        ld_rd(8'h20); check("R7 linear word2", 1'b1, 36'h333333333);
        ld_rd(8'h21); check("R7 linear word3", 1'b1, 36'h444444444);

        // interleaved read burst from 0x21: 1,0,3,2 then wrap; rw low ignored (R9)
        burst_mode = 1'b1;
        ld_rd(8'h21);            check("R8 il word0", 1'b1, 36'h444444444);
        adv_step(1'b0, '0);      check("R8 R9 il word1", 1'b1, 36'h333333333);
        adv_step(1'b0, '0);      check("R8 il word2", 1'b1, 36'h222222222);
        adv_step(1'b0, '0);      check("R8 il word3", 1'b1, 36'h111111111);
        adv_step(1'b0, '0);      check("R6 il wrap", 1'b1, 36'h444444444);

        // linear read burst from 0x23 with a held edge, then new load
        burst_mode = 1'b0;
        ld_rd(8'h23);            check("R7 lin read word0", 1'b1, 36'h222222222);
        adv_step(1'b1, '0);      check("R7 lin read word1", 1'b1, 36'h333333333);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'h0, '0, 1'b0);
        check("R10 held edge in burst", 1'b1, 36'h333333333);
        adv_step(1'b1, '0);      check("R7 lin read word2", 1'b1, 36'h444444444);
        adv_step(1'b1, '0);      check("R7 lin read word3", 1'b1, 36'h111111111);
        adv_step(1'b1, '0);      check("R6 lin wrap", 1'b1, 36'h222222222);
        ld_rd(8'h10);            check("R12 new load ends burst", 1'b1, 36'h0AFFE55FF);

        // write data lag across a held edge
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 4'h0, '0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 4'hF, 36'h00000DEAD, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 4'hF, 36'h5A5A5A5A5, 1'b0);
        ld_rd(8'h30);            check("R10 R5 write data after held edge", 1'b1, 36'h5A5A5A5A5);

        // each enable alone deselects
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 4'hF, '0, 1'b0);
        check("R2 sel_b_n high", 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h30, 4'hF, '0, 1'b0);
        check("R2 sel_c low", 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h30, 4'hF, '0, 1'b0);
        check("R2 sel_a_n high", 1'b0, '0);
        ld_rd(8'h30);            check("R4 reselect read", 1'b1, 36'h5A5A5A5A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule